// File: doc/BRIEF.md
# Write-Completion Status Responder

This block sits on the read path of a byte-wide non-volatile memory. It shapes the byte returned to the host while the memory's self-timed programming cycle is running. It records the address and data of the most recent byte loaded before programming began.

While the busy flag is high, a read does not return array contents. It returns a status word instead. The top bit of that word is the inverse of bit 7 of the last loaded byte, so a host polling that address sees a mismatch until the cycle ends. The next bit flips on every read during the cycle, so a host can also detect completion by watching it stop changing. Once busy drops, reads pass the array data through unchanged.

A protection-violation flag turns the status reporting off. While the flag is high, reads return plain array data and the flipping bit does not advance. The write buffer and the array are outside this block. The block receives the busy flag, the load events and the array read data from them.

Top module: `wcsr_top`

## Requirements
- R1: After reset, `rdData` is all zeros.
- R2: A read strobe taken while `busyIn` is low loads `arrData` into `rdData`. The new value is visible on the clock edge that samples the strobe.
- R3: A load (`loadValid`) taken while `busyIn` is low records `loadAddr` and `loadData`. When several loads occur, the last one becomes the polling reference.
- R4: A read taken while `busyIn` is high and `protIn` is low, at the recorded address, returns bit 7 equal to the inverse of bit 7 of the recorded data.
- R5: A read in status mode at any other address, or before any load has been recorded, returns bit 7 as 0.
- R6: Bit 6 of each status-mode read is the inverse of bit 6 of the previous status-mode read. Idle clocks and non-status reads do not advance it. Its first value is not specified.
- R7: Bits 5 down to 0 of a status-mode read are zero.
- R8: A load that arrives while `busyIn` is high is ignored, and the earlier reference stays in force.
- R9: `rdData` holds its value in cycles without a read strobe.
- R10: While `protIn` is high, reads return `arrData` even when `busyIn` is high, and bit 6 does not advance.
- R11: The mode of a read is set by `busyIn` in the same cycle as the strobe. A strobe in the cycle where busy falls returns array data. A strobe in the cycle where busy rises returns status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busyIn | input | 1 | Programming cycle in progress |
| protIn | input | 1 | Protection violation; disables status reporting |
| loadValid | input | 1 | One-cycle byte-load event |
| loadAddr | input | ADDR_W | Address of the loaded byte |
| loadData | input | DATA_W | Data of the loaded byte |
| rdStrobe | input | 1 | One-cycle read access |
| rdAddr | input | ADDR_W | Read address |
| arrData | input | DATA_W | Array read data for `rdAddr` |
| rdData | output | DATA_W | Registered read data returned to the host |

## Verification
The mode choice and a change of the busy flag can fall in the same cycle. The bench places a read strobe on exactly the edge where busy falls, and then on the edge where it rises. It judges the first read against the array byte and the second against the status word computed from the stored reference.

A load event and the busy flag can also coincide. The bench issues a load in a busy cycle and then polls both the old and the new address. The old address must still show the inverted bit and the new one must not.

// File: rtl/wcsr_pkg.sv
package wcsr_pkg;

  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rdSrcT;

  typedef struct packed {
    logic  captureLoad;
    logic  flipToggle;
    rdSrcT rdSrc;
  } strobeT;

endpackage

// File: rtl/wcsr_ctrl.sv
module wcsr_ctrl
  import wcsr_pkg::*;
(
  input  logic   busyIn,
  input  logic   protIn,
  input  logic   loadValid,
  input  logic   rdStrobe,
  output strobeT strobes
);

  logic statusMode;

  always_comb begin
    statusMode          = busyIn && !protIn;
    strobes.captureLoad = loadValid && !busyIn;
    strobes.flipToggle  = rdStrobe && statusMode;
    if (!rdStrobe)       strobes.rdSrc = SRC_HOLD;
    else if (statusMode) strobes.rdSrc = SRC_STATUS;
    else                 strobes.rdSrc = SRC_ARRAY;
  end

endmodule

// File: rtl/wcsr_datapath.sv
module wcsr_datapath
  import wcsr_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic              busyIn,
  input  logic              protIn,
  input  logic              rdStrobe,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DP_BIT = DATA_W - 1;
  localparam int TB_BIT = DATA_W - 2;

  logic [ADDR_W-1:0] lastAddr;
  logic [DATA_W-1:0] lastData;
  logic              haveLast;
  logic              toggleQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              addrHit;
  logic [DATA_W-1:0] statusWord;

  assign addrHit = haveLast && (rdAddr == lastAddr);

  for (genvar i = 0; i < DATA_W; i++) begin : g_status
    if (i == DP_BIT) begin : g_dp
      assign statusWord[i] = addrHit ? ~lastData[DP_BIT] : 1'b0;
    end else if (i == TB_BIT) begin : g_tb
      assign statusWord[i] = toggleQ;
    end else begin : g_rsv
      assign statusWord[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
      lastData <= '0;
      haveLast <= 1'b0;
      toggleQ  <= 1'b0;
      rdDataQ  <= '0;
    end else begin
      if (strobes.captureLoad) begin
        lastAddr <= loadAddr;
        lastData <= loadData;
        haveLast <= 1'b1;
      end
      if (strobes.flipToggle) toggleQ <= ~toggleQ;
      case (strobes.rdSrc)
        SRC_ARRAY:  rdDataQ <= arrData;
        SRC_STATUS: rdDataQ <= statusWord;
        default:    rdDataQ <= rdDataQ;
      endcase
    end
  end

  assign rdData = rdDataQ;

  assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !busyIn) |=> (rdData == $past(arrData)));

  assert_prot_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && protIn) |=> (rdData == $past(arrData)));

  assert_poll_invert_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && busyIn && !protIn && haveLast && rdAddr == lastAddr)
      |=> (rdData[DP_BIT] != $past(lastData[DP_BIT])));

  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && busyIn && !protIn) |=> (rdData[TB_BIT-1:0] == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));

  assert_busy_load_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && busyIn) |=> ($stable(lastData) && $stable(lastAddr)));

  assert_toggle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && busyIn && !protIn) |=> $stable(toggleQ));

endmodule

// File: rtl/wcsr_top.sv
module wcsr_top
  import wcsr_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busyIn,
  input  logic              protIn,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrData,
  output logic [DATA_W-1:0] rdData
);

  strobeT strobes;

  wcsr_ctrl u_ctrl (
    .busyIn    (busyIn),
    .protIn    (protIn),
    .loadValid (loadValid),
    .rdStrobe  (rdStrobe),
    .strobes   (strobes)
  );

  wcsr_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busyIn    (busyIn),
    .protIn    (protIn),
    .rdStrobe  (rdStrobe),
    .loadValid (loadValid),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .rdAddr    (rdAddr),
    .arrData   (arrData),
    .rdData    (rdData)
  );

endmodule

// File: tb/sim_wcsr_top.sv
module sim_wcsr_top;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busyIn = 1'b0, protIn = 1'b0, loadValid = 1'b0, rdStrobe = 1'b0;
  logic [AW-1:0] loadAddr = '0, rdAddr = '0;
  logic [DW-1:0] loadData = '0, arrData = '0;
  logic [DW-1:0] rdData;

  int errs = 0;
  int checks = 0;
  logic prevTb;
  logic [DW-1:0] got;

  always #10 clk = ~clk;

  wcsr_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .protIn(protIn),
    .loadValid(loadValid), .loadAddr(loadAddr), .loadData(loadData),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .arrData(arrData), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    loadValid = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic [DW-1:0] arr, output logic [DW-1:0] r);
    @(negedge clk);
    rdStrobe = 1'b1; rdAddr = a; arrData = arr;
    @(negedge clk);
    rdStrobe = 1'b0;
    r = rdData;
  endtask

  task automatic setBusy(input logic b);
    @(negedge clk);
    busyIn = b;
  endtask

  initial begin
    #4_000_000;
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset value", rdData, 8'h00);
    rstN = 1'b1;

    // R5: status read before any load recorded
    setBusy(1'b1);
    doRead(4'd3, 8'hFF, got);
    chk("R5 no reference yet bit7", {got[7], 7'b0}, 8'h00);
    prevTb = got[6];
    setBusy(1'b0);

    // R2: idle reads pass array data, sweep all addresses
    for (int a = 0; a < 16; a++) begin
      doRead(a[AW-1:0], 8'(a * 17) ^ 8'h5A, got);
      chk("R2 idle passthrough", got, 8'(a * 17) ^ 8'h5A);
    end

    // R3/R4/R7: load then poll, sweep data and addresses
    for (int k = 0; k < 64; k++) begin
      logic [DW-1:0] d;
      logic [AW-1:0] a;
      d = 8'(k * 37 + 3);
      a = 4'(k);
      doLoad(a, d);
      setBusy(1'b1);
      doRead(a, ~d, got);
      chk("R4 poll bit7 inverted", {got[7], 7'b0}, {~d[7], 7'b0});
      chk("R7 reserved zero", {2'b00, got[5:0]}, 8'h00);
      chk("R6 toggle alternates", {7'b0, got[6]}, {7'b0, ~prevTb});
      prevTb = got[6];
      doRead(a ^ 4'd1, d, got);
      chk("R5 other address bit7", {got[7], 7'b0}, 8'h00);
      chk("R6 toggle alternates", {7'b0, got[6]}, {7'b0, ~prevTb});
      prevTb = got[6];
      setBusy(1'b0);
      doRead(a, d, got);
      chk("R2 true data after completion", got, d);
    end

    // R3: page of loads, last wins
    doLoad(4'd2, 8'h80);
    doLoad(4'd6, 8'h01);
    doLoad(4'd7, 8'h7F);
    setBusy(1'b1);
    doRead(4'd7, 8'h00, got);
    chk("R3 last load is reference", {got[7], 7'b0}, 8'h80);
    prevTb = got[6];
    doRead(4'd2, 8'h00, got);
    chk("R3 earlier load not reference", {got[7], 7'b0}, 8'h00);
    prevTb = got[6];

    // R9: hold between reads, and idle clocks do not advance toggle
    repeat (5) @(negedge clk);
    chk("R9 hold without strobe", rdData, got);
    doRead(4'd7, 8'h00, got);
    chk("R6 idle clocks no advance", {7'b0, got[6]}, {7'b0, ~prevTb});
    prevTb = got[6];

    // R8: load during busy ignored
    doLoad(4'd9, 8'h00);
    doRead(4'd7, 8'h00, got);
    chk("R8 old reference kept", {got[7], 7'b0}, 8'h80);
    prevTb = got[6];
    doRead(4'd9, 8'h00, got);
    chk("R8 busy load not recorded", {got[7], 7'b0}, 8'h00);
    prevTb = got[6];

    // R10: protection violation disables status
    @(negedge clk); protIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      doRead(4'd7, 8'(8'hC3 + k), got);
      chk("R10 prot passthrough", got, 8'(8'hC3 + k));
    end
    @(negedge clk); protIn = 1'b0;
    doRead(4'd7, 8'h00, got);
    chk("R10 toggle frozen under prot", {7'b0, got[6]}, {7'b0, ~prevTb});
    prevTb = got[6];

    // R11: strobe on the edge busy falls -> array data
    @(negedge clk);
    busyIn = 1'b0; rdStrobe = 1'b1; rdAddr = 4'd7; arrData = 8'h7F;
    @(negedge clk);
    rdStrobe = 1'b0;
    chk("R11 busy fall same cycle", rdData, 8'h7F);
    doRead(4'd7, 8'h7F, got);
    chk("R6 no toggle after completion", got, 8'h7F);

    // R11: strobe on the edge busy rises -> status
    @(negedge clk);
    busyIn = 1'b1; rdStrobe = 1'b1; rdAddr = 4'd7; arrData = 8'h7F;
    @(negedge clk);
    rdStrobe = 1'b0;
    chk("R11 busy rise same cycle", {rdData[7], 1'b0, rdData[5:0]}, 8'h80);
    chk("R6 toggle across cycles", {7'b0, rdData[6]}, {7'b0, ~prevTb});
    setBusy(1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule